// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial (I2C) target that holds the control bytes of a clock generator. It oversamples SCL and SDA with the system clock, recognises START and STOP, and answers one fixed seven-bit address. Its contents drive the rest of the chip as a flat parallel vector. Strap levels captured elsewhere at power-up arrive on an input and appear, read-only, at fixed bit positions. A constant identity byte also arrives on an input and is visible only to reads.

The register bank has no pointer. A write carries two filler bytes first, one for a command and one for a count. Both are acknowledged and thrown away. The data bytes that follow fill register 0, then 1, and so on. A read has no filler phase: it returns register 0, then 1, and onward, for as long as the host keeps acknowledging.

The controller states are IDLE (bus free), ADDR (shifting in the address byte), ADDR_ACK (pulling SDA low for a matching address), WR_BYTE (shifting in a write byte), WR_ACK (acknowledging it), RD_BYTE (driving a read byte, MSB first), RD_ACK (sampling the host's acknowledge) and WAIT (silent until the next START or STOP). The transitions are as follows:
- START moves any state to ADDR.
- STOP moves any state to IDLE.
- ADDR goes to ADDR_ACK on a match and to WAIT otherwise.
- ADDR_ACK goes to WR_BYTE or RD_BYTE according to the direction bit.
- WR_BYTE and WR_ACK alternate.
- RD_BYTE goes to RD_ACK. RD_ACK goes back to RD_BYTE on an ACK, or to WAIT on a NACK.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address is not acknowledged, and the block stays silent until the next START.
- R3: In a write, the first two bytes after the address (command and count) are acknowledged and change no register.
- R4: Write data bytes are stored, each acknowledged, into register 0, 1, 2 and onward in arrival order. Register k is ctrl_regs_o[8k+7:8k].
- R5: A read returns register 0, 1, 2 and onward, MSB first, moving on after each host ACK. Index 6 returns chip_id_i, and indices above 6 return 0x00.
- R6: After a host NACK on a read byte, the block releases SDA and drives nothing until a STOP or START.
- R7: Reset loads register 0 with 0x00 and registers 1 to 5 with 0xFF, apart from the strap positions.
- R8: Strap bits are read-only and always show the inputs: reg1[7]=strap_i[2], reg3[6]=strap_i[0], reg4[3]=strap_i[1], reg4[1]=strap_i[3]. Writing them has no effect.
- R9: Data bytes aimed at index 6 or beyond are acknowledged and discarded. The identity byte is unaffected.
- R10: A START or STOP in the middle of a byte abandons that byte, and no register changes.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 4 | Latched strap levels |
| chip_id_i | input | 8 | Constant identity byte returned at index 6 |
| ctrl_regs_o | output | 48 | Registers 0 to 5, register k at bits 8k+7:8k |

## Verification
A wrong state or counter shows up at the ports within one byte time. A wrong address decision gives a missing or spurious acknowledge on the ninth clock. A miscount of the filler bytes moves every stored byte by one register, which ctrl_regs_o shows as soon as STOP arrives. A read pointer that is off by one gives a wrong byte on the very next read. A lost NACK leaves SDA driven on the following clocks. A partial byte committed by mistake changes a register even though the transfer was aborted.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE,
        ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_WAIT
    } fsm_state_t;

    localparam int REG_W = 8;

    // bits of register k that reflect strap levels instead of storage
    function automatic logic [REG_W-1:0] ro_mask(input int k);
        unique case (k)
            1:       ro_mask = 8'h80;
            3:       ro_mask = 8'h40;
            4:       ro_mask = 8'h0A;
            default: ro_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] strap_bits(input int k, input logic [3:0] s);
        unique case (k)
            1:       strap_bits = {s[2], 7'b0};
            3:       strap_bits = {1'b0, s[0], 6'b0};
            4:       strap_bits = {4'b0, s[1], 1'b0, s[3], 1'b0};
            default: strap_bits = 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reset_value(input int k);
        reset_value = (k == 0) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/clkctl_bus_sync.sv
module clkctl_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[STAGES-1];
            sda_q <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int NUM_RW = 6,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [3:0]               strap_i,
    input  logic [REG_W-1:0]         chip_id_i,
    output logic [NUM_RW*REG_W-1:0]  regs_o,
    output logic [REG_W-1:0]         rd_data
);
    logic [NUM_RW-1:0][REG_W-1:0] store;
    logic [NUM_RW-1:0][REG_W-1:0] view;

    genvar k;
    generate
        for (k = 0; k < NUM_RW; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    store[k] <= reset_value(k);
                else if (wr_en && wr_idx == IDX_W'(k))
                    store[k] <= wr_data;
            end
            assign view[k] = (store[k] & ~ro_mask(k)) | strap_bits(k, strap_i);
            assign regs_o[k*REG_W +: REG_W] = view[k];
        end
    endgenerate

    always_comb begin
        if (rd_idx < IDX_W'(NUM_RW))
            rd_data = view[rd_idx];
        else if (rd_idx == IDX_W'(NUM_RW))
            rd_data = chip_id_i;
        else
            rd_data = '0;
    end

    // R9: the controller never aims a store beyond the writable bank
    assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDX_W'(NUM_RW));

    // R3: storage holds whenever no data byte is committed
    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store));
endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave
    import clkctl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         NUM_RW_REGS = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe_o,
    input  logic [3:0]                    strap_i,
    input  logic [7:0]                    chip_id_i,
    output logic [NUM_RW_REGS*REG_W-1:0]  ctrl_regs_o
);
    localparam int IDX_W = $clog2(NUM_RW_REGS + 2) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    fsm_state_t       state, st_n;
    logic [3:0]       bit_cnt, cnt_n;
    logic [7:0]       shreg, sh_n;
    logic [IDX_W-1:0] byte_cnt, bc_n, rd_idx, ri_n, data_idx;
    logic             m_nack, nack_n;
    logic             wr_en;
    logic [7:0]       rd_data;
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    clkctl_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    assign data_idx = byte_cnt - IDX_W'(2);

    clkctl_regbank #(.NUM_RW(NUM_RW_REGS), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(data_idx),
        .wr_data(shreg), .rd_idx(rd_idx), .strap_i(strap_i),
        .chip_id_i(chip_id_i), .regs_o(ctrl_regs_o), .rd_data(rd_data)
    );

    // next-state and datapath decisions
    always_comb begin
        st_n   = state;
        cnt_n  = bit_cnt;
        sh_n   = shreg;
        bc_n   = byte_cnt;
        ri_n   = rd_idx;
        nack_n = m_nack;
        wr_en  = 1'b0;
        if (stop_det) begin
            st_n = ST_IDLE;
        end else if (start_det) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
            ri_n  = '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_n  = {shreg[6:0], sda_lvl};
                        cnt_n = bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        st_n = (shreg[7:1] == SLAVE_ADDR) ? ST_ADDR_ACK : ST_WAIT;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_n = '0;
                        bc_n  = '0;
                        if (shreg[0]) begin
                            st_n = ST_RD_BYTE;
                            sh_n = rd_data;
                            ri_n = IDX_W'(1);
                        end else begin
                            st_n = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        sh_n  = {shreg[6:0], sda_lvl};
                        cnt_n = bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        st_n  = ST_WR_ACK;
                        wr_en = (byte_cnt >= IDX_W'(2)) && (data_idx < IDX_W'(NUM_RW_REGS));
                        if (byte_cnt != IDX_MAX) bc_n = byte_cnt + IDX_W'(1);
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        st_n  = ST_WR_BYTE;
                        cnt_n = '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        sh_n  = {shreg[6:0], 1'b0};
                        cnt_n = bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) st_n = ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        nack_n = sda_lvl;
                    end else if (scl_fall) begin
                        if (m_nack) begin
                            st_n = ST_WAIT;
                        end else begin
                            st_n  = ST_RD_BYTE;
                            sh_n  = rd_data;
                            cnt_n = '0;
                            if (rd_idx != IDX_MAX) ri_n = rd_idx + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            rd_idx   <= '0;
            m_nack   <= 1'b0;
        end else begin
            state    <= st_n;
            bit_cnt  <= cnt_n;
            shreg    <= sh_n;
            byte_cnt <= bc_n;
            rd_idx   <= ri_n;
            m_nack   <= nack_n;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD_BYTE:             sda_oe_o = ~shreg[7];
            default:                sda_oe_o = 1'b0;
        endcase
    end

    // R1: a START seen on the bus always opens an address phase
    assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> state == ST_ADDR);

    // R1: a STOP always frees the line and idles the controller
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe_o));

    // R11: drive stays put while SCL is high, except at START/STOP
    assert_sda_quiet_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && !scl_fall && !scl_rise && !start_det && !stop_det) |=> $stable(sda_oe_o));

    // R10: the bit counter never passes one full byte
    assert_bitcnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);
endmodule

// File: tb/clkctl_i2c_slave_tb.sv
module clkctl_i2c_slave_tb_top;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [3:0]  strap = 4'b0101;
    logic [7:0]  chip_id = 8'h59;
    logic [47:0] regs;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] m_store [6];
    logic [7:0] wd [10];
    logic [7:0] rd [10];

    always #2.5 clk = ~clk;

    clkctl_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .chip_id_i(chip_id),
        .ctrl_regs_o(regs)
    );

    function automatic logic [7:0] rmask(int k);
        case (k)
            1: return 8'h80;
            3: return 8'h40;
            4: return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sbits(int k, logic [3:0] s);
        case (k)
            1: return {s[2], 7'b0};
            3: return {1'b0, s[0], 6'b0};
            4: return {4'b0, s[1], 1'b0, s[3], 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_view(int k);
        if (k < 6) return (m_store[k] & ~rmask(k)) | sbits(k, strap);
        if (k == 6) return chip_id;
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hp();
        scl = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hp();
        scl = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic wbit(bit b);
        sda_m = b; hp();
        scl = 1'b1; hp();
        scl = 1'b0; hp();
    endtask

    task automatic rbit(output bit b, output bit steady);
        bit a;
        sda_m = 1'b1; hp();
        scl = 1'b1;
        repeat (2) @(negedge clk);
        a = sda_line;
        repeat (H - 2) @(negedge clk);
        b = sda_line;
        steady = (a == b);
        scl = 1'b0; hp();
    endtask

    task automatic tx_byte(logic [7:0] v, output bit nack);
        bit st;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(nack, st);
    endtask

    task automatic rx_byte(bit host_nack, output logic [7:0] v);
        bit b, st;
        bit all_st = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            rbit(b, st);
            v[i] = b;
            all_st &= st;
        end
        chk("R11 sda steady while scl high", {7'b0, all_st}, 8'h01);
        wbit(host_nack);
        sda_m = 1'b1;
    endtask

    task automatic do_write(int n, logic [7:0] cmd, logic [7:0] cnt);
        bit nk;
        i2c_start();
        tx_byte(8'hD2, nk); chk("R2 write address ack", {7'b0, nk}, 8'h00);
        tx_byte(cmd, nk);   chk("R3 command ack", {7'b0, nk}, 8'h00);
        tx_byte(cnt, nk);   chk("R3 count ack", {7'b0, nk}, 8'h00);
        for (int i = 0; i < n; i++) begin
            tx_byte(wd[i], nk);
            chk(i < 6 ? "R4 data ack" : "R9 overflow ack", {7'b0, nk}, 8'h00);
            if (i < 6) m_store[i] = wd[i];
        end
        i2c_stop();
    endtask

    task automatic do_read(int n);
        bit nk;
        i2c_start();
        tx_byte(8'hD3, nk); chk("R2 read address ack", {7'b0, nk}, 8'h00);
        for (int i = 0; i < n; i++) rx_byte(i == n - 1, rd[i]);
        i2c_stop();
    endtask

    task automatic check_regs(string req);
        for (int k = 0; k < 6; k++) chk(req, regs[8*k +: 8], exp_view(k));
    endtask

    initial begin
        bit nk;
        logic [7:0] v;
        int seed;
        seed = $urandom(32'h5eed);
        for (int k = 0; k < 6; k++) m_store[k] = (k == 0) ? 8'h00 : 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7 reset values
        check_regs("R7 reset value");
        chk("R1 idle releases sda", {7'b0, sda_oe}, 8'h00);

        // R5 read after reset, including identity and past-end bytes
        do_read(9);
        for (int i = 0; i < 9; i++) chk("R5 streamed read", rd[i], exp_view(i));

        // R3/R4 command and count of all ones must not land anywhere
        wd[0] = 8'h12; wd[1] = 8'h34; wd[2] = 8'h56;
        do_write(3, 8'hFF, 8'hFF);
        check_regs("R4 ordered store, R3 filler ignored");

        // R8/R9 full write of zeros plus overflow bytes
        for (int i = 0; i < 8; i++) wd[i] = 8'h00;
        do_write(8, 8'h00, 8'h08);
        check_regs("R8 strap bits kept");
        do_read(7);
        chk("R9 identity untouched", rd[6], 8'h59);

        // R2 foreign address is ignored
        i2c_start();
        tx_byte(8'hA4, nk); chk("R2 foreign address nack", {7'b0, nk}, 8'h01);
        tx_byte(8'h00, nk); chk("R2 silent after mismatch", {7'b0, nk}, 8'h01);
        i2c_stop();
        check_regs("R2 no change after mismatch");

        // R10 STOP in mid-byte
        i2c_start();
        tx_byte(8'hD2, nk); tx_byte(8'h00, nk); tx_byte(8'h00, nk);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        i2c_stop();
        check_regs("R10 stop abort");

        // R10 repeated START in mid-byte, then read register 0
        i2c_start();
        tx_byte(8'hD2, nk); tx_byte(8'h00, nk); tx_byte(8'h00, nk);
        for (int i = 0; i < 3; i++) wbit(1'b1);
        i2c_start();
        tx_byte(8'hD3, nk); chk("R10 restart address ack", {7'b0, nk}, 8'h00);
        rx_byte(1'b1, v);
        chk("R10 restart read", v, exp_view(0));
        // R6 after NACK the line stays released
        rx_byte(1'b1, v);
        chk("R6 released after nack", v, 8'hFF);
        i2c_stop();
        check_regs("R10 no partial store");

        // R8 straps follow inputs
        strap = 4'b1010;
        repeat (2) @(negedge clk);
        check_regs("R8 strap follows input");

        // random writes with readback
        for (int it = 0; it < 10; it++) begin
            int n;
            n = $urandom_range(0, 8);
            for (int i = 0; i < n; i++) wd[i] = 8'($urandom());
            do_write(n, 8'($urandom()), 8'($urandom()));
            check_regs("R4 random store");
            do_read(8);
            for (int i = 0; i < 8; i++) chk("R5 random readback", rd[i], exp_view(i));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule